// File: doc/BRIEF.md
# Interrupt Context Bank Controller

This block holds a fixed stack of hardware register banks. When the CPU accepts an ordinary maskable interrupt, it saves the entry context into a bank in a single cycle. That context is the fifteen general registers, the global base register, both halves of the multiply-accumulate register, the procedure return register and the vector number. A return from the handler restores the same context. A bank-number pointer selects the bank. It counts up after each save and counts down before each restore, so the banks behave as a last-in, first-out stack of contexts.

The entry sequencer presents a save request together with the kind of exception being taken. Only ordinary interrupts use the banks. When every bank is occupied, an overflow-enable input sets the outcome. With the input clear, the block tells the sequencer to push the context to the memory stack. With the input set, the block raises a bank overflow exception. A restore request with no bank in use raises a bank error and leaves the state as it was. The current pointer and a full flag are always visible.

Top module: `intr_bank_ctrl`

## Requirements
- R1: After reset the pointer reads 0. The full flag, the stack-save, overflow and bank-error pulses, and the restore-valid strobe are all low.
- R2: A save request of kind 0 (ordinary interrupt) with the pointer below NUM_BANKS stores `ctx_i` into bank[pointer`]` and increments the pointer, visible one cycle after the request.
- R3: A restore request with the pointer above 0 decrements the pointer. One cycle after the request, `ctx_o` carries the contents of bank[new pointer] and `ctx_valid_o` is high for that one cycle.
- R4: `full_o` is high exactly when the pointer equals NUM_BANKS.
- R5: A kind-0 save while full with `ovf_en_i` = 0 writes no bank and leaves the pointer unchanged. It pulses `stack_save_o` for one cycle, one cycle after the request.
- R6: A kind-0 save while full with `ovf_en_i` = 1 writes no bank and leaves the pointer unchanged. It pulses `ovf_exc_o` for one cycle, one cycle after the request, and `stack_save_o` stays low.
- R7: A save request of kind 1 (non-maskable), 2 (user break) or 3 (error or instruction exception) writes no bank, leaves the pointer unchanged and raises no pulse.
- R8: A restore request with the pointer at 0 pulses `bank_err_o` one cycle later. The pointer stays 0 and `ctx_valid_o` stays low.
- R9: When save and restore requests arrive in the same cycle, the save is handled according to R2, R5, R6 or R7, and the restore is ignored.
- R10: Each bank returns the context of the most recent save into it, whatever saves and restores happened at other depths. On `ctx_i`/`ctx_o`, general register k sits at bits [32k+31:32k] for k = 0..14. GBR, MACH, MACL and PR follow as words 15 to 18, and the vector number occupies bits [608+VEC_W-1:608].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| save_req_i | input | 1 | Context save request from the entry sequencer |
| save_kind_i | input | 2 | Exception kind: 0 interrupt, 1 non-maskable, 2 user break, 3 error/instruction |
| ovf_en_i | input | 1 | 1: overflow exception when full; 0: fall back to stack save |
| restore_req_i | input | 1 | Context restore request on handler return |
| ctx_i | input | 19*32+VEC_W | Context to save |
| ctx_o | output | 19*32+VEC_W | Restored context |
| ctx_valid_o | output | 1 | `ctx_o` valid strobe |
| stack_save_o | output | 1 | Banks full, sequencer must save to stack |
| ovf_exc_o | output | 1 | Bank overflow exception |
| bank_err_o | output | 1 | Restore with no bank in use |
| bank_ptr_o | output | $clog2(NUM_BANKS+1) | Current bank-number pointer |
| full_o | output | 1 | All banks in use |

## Verification
The hardest states to reach are the ones at full depth. There, the overflow-enable choice, save requests of the non-interrupt kinds and a save coinciding with a restore must each leave the pointer and every bank untouched. The bench first fills all fifteen banks with contexts derived from the bank index. At full depth it sweeps the overflow-enable choice, every exception kind and simultaneous requests. It then unwinds the stack, compares every restored field against its own model, and refills part way with new data to confirm that the overwritten banks return the newer contexts.

// File: rtl/intr_bank_pkg.sv
package intr_bank_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned N_WORDS  = 19;  // r0..r14, gbr, mach, macl, pr

  typedef enum logic [1:0] {
    KIND_IRQ  = 2'd0,
    KIND_NMI  = 2'd1,
    KIND_UBRK = 2'd2,
    KIND_EXC  = 2'd3
  } exc_kind_e;
endpackage

// File: rtl/intr_bank_ptr.sv
module intr_bank_ptr
  import intr_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 15,
  localparam int unsigned PTR_W = $clog2(NUM_BANKS + 1),
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_req_i,
  input  logic [1:0]       save_kind_i,
  input  logic             ovf_en_i,
  input  logic             restore_req_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             full_o,
  output logic             stack_save_o,
  output logic             ovf_exc_o,
  output logic             bank_err_o
);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(NUM_BANKS);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic stack_q, ovf_q, err_q;
  logic is_irq, is_full, do_save, do_rest, want_rest;

  assign is_full   = (ptr_q == PTR_MAX);
  assign is_irq    = save_req_i && (exc_kind_e'(save_kind_i) == KIND_IRQ);
  assign do_save   = is_irq && !is_full;
  // save requests of any kind block a same-cycle restore
  assign want_rest = restore_req_i && !save_req_i;
  assign do_rest   = want_rest && (ptr_q != '0);

  always_comb begin
    ptr_d = ptr_q;
    if (do_save)      ptr_d = ptr_q + 1'b1;
    else if (do_rest) ptr_d = ptr_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      stack_q <= 1'b0;
      ovf_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      stack_q <= is_irq && is_full && !ovf_en_i;
      ovf_q   <= is_irq && is_full && ovf_en_i;
      err_q   <= want_rest && (ptr_q == '0);
    end
  end

  assign wr_en_o      = do_save;
  assign wr_idx_o     = IDX_W'(ptr_q);
  assign rd_en_o      = do_rest;
  assign rd_idx_o     = IDX_W'(ptr_q - 1'b1);
  assign ptr_o        = ptr_q;
  assign full_o       = is_full;
  assign stack_save_o = stack_q;
  assign ovf_exc_o    = ovf_q;
  assign bank_err_o   = err_q;

  p_ptr_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_MAX);
  p_save_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_save |=> ptr_q == $past(ptr_q) + 1'b1);
  p_rest_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_rest |=> ptr_q == $past(ptr_q) - 1'b1);
  p_full_stack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_irq && is_full && !ovf_en_i) |=> stack_q && !ovf_q && $stable(ptr_q));
  p_full_ovf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_irq && is_full && ovf_en_i) |=> ovf_q && !stack_q && $stable(ptr_q));
  p_no_bank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_req_i && !is_irq) |=> $stable(ptr_q) && !stack_q && !ovf_q);
  p_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (want_rest && ptr_q == '0) |=> err_q && ptr_q == '0);
  p_pulse_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stack_q && ovf_q));
endmodule

// File: rtl/intr_bank_store.sv
module intr_bank_store #(
  parameter int unsigned NUM_BANKS = 15,
  parameter int unsigned CTX_W = 617,
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [CTX_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CTX_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  logic [CTX_W-1:0] bank_q [NUM_BANKS];
  logic [CTX_W-1:0] rd_q;
  logic             vld_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(b));
    always_ff @(posedge clk_i) begin
      if (sel) bank_q[b] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_en_i;
      if (rd_en_i) rd_q <= bank_q[rd_idx_i];
    end
  end

  assign rd_data_o  = rd_q;
  assign rd_valid_o = vld_q;

  p_wr_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> wr_idx_i < IDX_W'(NUM_BANKS));
  p_rd_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  p_rd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o && $stable(rd_q));
endmodule

// File: rtl/intr_bank_ctrl.sv
module intr_bank_ctrl
  import intr_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 15,
  parameter int unsigned VEC_W = 9,
  localparam int unsigned CTX_W = N_WORDS * WORD_W + VEC_W,
  localparam int unsigned PTR_W = $clog2(NUM_BANKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_req_i,
  input  logic [1:0]       save_kind_i,
  input  logic             ovf_en_i,
  input  logic             restore_req_i,
  input  logic [CTX_W-1:0] ctx_i,
  output logic [CTX_W-1:0] ctx_o,
  output logic             ctx_valid_o,
  output logic             stack_save_o,
  output logic             ovf_exc_o,
  output logic             bank_err_o,
  output logic [PTR_W-1:0] bank_ptr_o,
  output logic             full_o
);
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic             wr_en, rd_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  intr_bank_ptr #(.NUM_BANKS(NUM_BANKS)) i_ptr (
    .clk_i,
    .rst_ni,
    .save_req_i,
    .save_kind_i,
    .ovf_en_i,
    .restore_req_i,
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .rd_en_o      (rd_en),
    .rd_idx_o     (rd_idx),
    .ptr_o        (bank_ptr_o),
    .full_o,
    .stack_save_o,
    .ovf_exc_o,
    .bank_err_o
  );

  intr_bank_store #(.NUM_BANKS(NUM_BANKS), .CTX_W(CTX_W)) i_store (
    .clk_i,
    .rst_ni,
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (ctx_i),
    .rd_en_i    (rd_en),
    .rd_idx_i   (rd_idx),
    .rd_data_o  (ctx_o),
    .rd_valid_o (ctx_valid_o)
  );

  p_err_no_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_err_o |-> !ctx_valid_o);
  p_full_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_save_o |-> full_o);
endmodule

// File: tb/test_intr_bank_ctrl.sv
module test_intr_bank_ctrl;
  localparam int NB    = 15;
  localparam int VW    = 9;
  localparam int CW    = 19 * 32 + VW;
  localparam int PW    = $clog2(NB + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic save_req = 0, ovf_en = 0, restore_req = 0;
  logic [1:0] kind = '0;
  logic [CW-1:0] ctx_in = '0, ctx_out;
  logic ctx_valid, stack_save, ovf_exc, bank_err, full;
  logic [PW-1:0] ptr;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [CW-1:0] model_mem [NB];
  int model_ptr = 0;

  always #4 clk = ~clk;

  intr_bank_ctrl #(.NUM_BANKS(NB), .VEC_W(VW)) i_intr_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .save_req_i(save_req), .save_kind_i(kind),
    .ovf_en_i(ovf_en), .restore_req_i(restore_req), .ctx_i(ctx_in),
    .ctx_o(ctx_out), .ctx_valid_o(ctx_valid), .stack_save_o(stack_save),
    .ovf_exc_o(ovf_exc), .bank_err_o(bank_err), .bank_ptr_o(ptr), .full_o(full)
  );

  function automatic logic [CW-1:0] mk_ctx(int s);
    logic [CW-1:0] v;
    v = '0;
    for (int k = 0; k < 19; k++)
      v[32*k +: 32] = 32'(s * 32'h9E3779B1 + k * 32'h01010101 + 32'h55);
    v[608 +: VW] = VW'(s * 7 + 64);
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_ctx(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; applies one request, checks outputs at next negedge
  task automatic op(bit sv, int k, bit rs, bit oen, int seed, string ctag);
    bit e_stack = 0, e_ovf = 0, e_err = 0, e_valid = 0;
    logic [CW-1:0] e_ctx = '0;
    string tag = "idle";
    save_req = sv; kind = 2'(k); restore_req = rs; ovf_en = oen;
    ctx_in = mk_ctx(seed);
    if (sv) begin
      if (k == 0) begin
        if (model_ptr < NB) begin
          model_mem[model_ptr] = ctx_in; model_ptr++; tag = "R2";
        end else if (oen) begin e_ovf = 1; tag = "R6"; end
        else begin e_stack = 1; tag = "R5"; end
      end else tag = "R7";
      if (rs) tag = {tag, "/R9"};
    end else if (rs) begin
      if (model_ptr == 0) begin e_err = 1; tag = "R8"; end
      else begin
        model_ptr--; e_valid = 1; e_ctx = model_mem[model_ptr]; tag = "R3";
      end
    end
    @(negedge clk);
    save_req = 0; restore_req = 0; kind = '0; ovf_en = 0;
    chk({tag, " ptr"}, int'(ptr), model_ptr);
    chk("R4 full", int'(full), int'(model_ptr == NB));
    chk({tag, " stack_save"}, int'(stack_save), int'(e_stack));
    chk({tag, " ovf_exc"}, int'(ovf_exc), int'(e_ovf));
    chk({tag, " bank_err"}, int'(bank_err), int'(e_err));
    chk({tag, " ctx_valid"}, int'(ctx_valid), int'(e_valid));
    if (e_valid) chk_ctx({ctag, " ctx"}, ctx_out, e_ctx);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ptr", int'(ptr), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 pulses", int'({stack_save, ovf_exc, bank_err, ctx_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    op(0, 0, 0, 0, 0, "");
    op(0, 0, 1, 0, 0, "R3");        // R8 underflow from reset
    for (int pass = 0; pass < 2; pass++) begin
      // fill, with non-interrupt kinds swept at each depth (R7)
      for (int b = 0; b < NB; b++) begin
        op(1, 1 + (b % 3), 0, b[0], 900 + b, "");
        op(1, 0, 0, 0, 100 * pass + b, "");
      end
      // full-depth sweep: R5, R6, R7, R9
      for (int oe = 0; oe < 2; oe++)
        for (int k = 0; k < 4; k++) begin
          op(1, k, 0, oe[0], 777, "");
          op(1, k, 1, oe[0], 778, "");
        end
      op(0, 0, 0, 0, 0, "");
      // partial unwind, then overwrite (R10)
      for (int b = 0; b < 5; b++) op(0, 0, 1, 0, 0, "R3");
      op(1, 0, 0, 0, 5000 + pass, "");
      op(1, 0, 1, 1, 5100 + pass, "");   // R9 save wins
      op(1, 2, 1, 0, 5200, "");          // R9 non-irq save blocks restore
      for (int b = 0; b < NB; b++) op(0, 0, 1, 0, 0, "R10");
      op(0, 0, 1, 0, 0, "R3");
      op(0, 0, 1, 1, 0, "R3");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule